// File: doc/BRIEF.md
# Serial Link Request Transmitter

This block turns a parallel request from the link layer into a framed serial bit stream on a single request wire toward the physical-layer device. A request names one of four kinds (cable bus request, backplane bus request with per-packet priority, register read, register write), a three-bit request code, and the payload fields that the kind needs. The block accepts the request through a valid/ready handshake and then drives one bit per clock. It takes the most significant bit of each field first, opens the frame with a 1 and closes it with a 0.

Frame length depends on the kind: 7 bits for a cable request, 11 for a backplane request, 9 for a register read and 17 for a register write. Between frames the wire rests low. Ready drops on acceptance and rises again in the cycle that carries the stop bit, so a new frame can follow with no idle gap.

Top module: `lrq_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `lreq` is 0 and `req_ready` is 1.
- R2: Every frame's first bit on `lreq` is 1, and its last bit is 0.
- R3: Kind code 0 (cable) sends 7 bits: start, request code (3 bits), speed (2 bits), stop.
- R4: Kind code 1 (backplane) sends 11 bits: start, request code (3), speed (2), priority (4), stop. The priority comes from the request, not from stored state.
- R5: Kind code 2 (register read) sends 9 bits: start, request code (3), address (4), stop.
- R6: Kind code 3 (register write) sends 17 bits: start, request code (3), address (4), write data (8), stop.
- R7: Each field goes out most significant bit first, and the fields keep the order given in R3 to R6.
- R8: The start bit appears on `lreq` in the cycle after the accepting edge. `req_ready` is 0 from the accepting edge until the edge that drives the stop bit, so it stays low for the frame length minus one cycle. A request held valid in the stop-bit cycle is accepted at the next edge, and its start bit follows the stop bit directly.
- R9: Request inputs that change while `req_ready` is 0 have no effect on the frame in flight. The next frame carries the values present at its own accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_kind | input | 2 | 0 cable, 1 backplane, 2 register read, 3 register write |
| req_code | input | 3 | Request code field |
| req_speed | input | 2 | Speed code (bus requests) |
| req_prio | input | 4 | Per-packet priority (backplane) |
| req_addr | input | 4 | Register address (read/write) |
| req_wdata | input | 8 | Register write data |
| lreq | output | 1 | Serial request line, idle low |

## Verification
The bench chains requests back to back, holding valid through the stop-bit cycle. A design that left an idle bit between frames, or that took the next request one cycle early and cut off the stop bit, would lose step with the reference stream. While a frame is in flight the bench scrambles every request field. A transmitter that read its inputs live instead of latching them would put garbage bits into the frame. Each kind is sent with asymmetric field values, so a swapped field order, reversed bit order or wrong frame length shows up as a bit mismatch or as a wrong count of ready-low cycles.

// File: rtl/lrq_pkg.sv
// Package: shared request-kind encoding and field widths for the serial
// link request transmitter. Assumes the kind code is 2 bits wide.
package lrq_pkg;

    typedef enum logic [1:0] {
        KIND_CABLE     = 2'd0,
        KIND_BACKPLANE = 2'd1,
        KIND_REG_RD    = 2'd2,
        KIND_REG_WR    = 2'd3
    } req_kind_t;

    localparam int CODE_W_DEF  = 3;
    localparam int SPEED_W_DEF = 2;
    localparam int PRIO_W_DEF  = 4;
    localparam int ADDR_W_DEF  = 4;
    localparam int DATA_W_DEF  = 8;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lrq_frame_build.sv
// Module: lrq_frame_build
// Purely combinational. Assembles the framed bit pattern for one request,
// left-aligned in a FRAME_W-bit word, together with its length in bits.
// Assumes FRAME_W is at least the longest frame length.
module lrq_frame_build
    import lrq_pkg::*;
#(
    parameter int CODE_W  = CODE_W_DEF,
    parameter int SPEED_W = SPEED_W_DEF,
    parameter int PRIO_W  = PRIO_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int FRAME_W = 17,
    parameter int LEN_W   = 5
) (
    input  req_kind_t            kind,
    input  logic [CODE_W-1:0]    code,
    input  logic [SPEED_W-1:0]   speed,
    input  logic [PRIO_W-1:0]    prio,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [FRAME_W-1:0]   frame,
    output logic [LEN_W-1:0]     len
);
    localparam int CAB_LEN = 2 + CODE_W + SPEED_W;
    localparam int BKP_LEN = CAB_LEN + PRIO_W;
    localparam int RD_LEN  = 2 + CODE_W + ADDR_W;
    localparam int WR_LEN  = RD_LEN + DATA_W;

    // Pick the field layout for the requested kind and left-align it.
    always_comb begin
        unique case (kind)
            KIND_CABLE: begin
                frame = FRAME_W'({1'b1, code, speed, 1'b0}) << (FRAME_W - CAB_LEN);
                len   = LEN_W'(CAB_LEN);
            end
            KIND_BACKPLANE: begin
                frame = FRAME_W'({1'b1, code, speed, prio, 1'b0}) << (FRAME_W - BKP_LEN);
                len   = LEN_W'(BKP_LEN);
            end
            KIND_REG_RD: begin
                frame = FRAME_W'({1'b1, code, addr, 1'b0}) << (FRAME_W - RD_LEN);
                len   = LEN_W'(RD_LEN);
            end
            default: begin
                frame = FRAME_W'({1'b1, code, addr, wdata, 1'b0}) << (FRAME_W - WR_LEN);
                len   = LEN_W'(WR_LEN);
            end
        endcase
    end

endmodule

// File: rtl/lrq_shift_out.sv
// Module: lrq_shift_out
// Loads a left-aligned frame and drives it out one bit per clock from a
// registered output, MSB first. Reports idle once the last bit is on the
// line, so a new load may follow directly. Assumes len >= 2.
module lrq_shift_out #(
    parameter int FRAME_W = 17,
    parameter int LEN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   len,
    output logic               line_q,
    output logic               idle
);
    logic [FRAME_W-1:0] sreg_q;
    logic [LEN_W-1:0]   rem_q;

    // Bit shifter and count of bits still to drive after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            rem_q  <= '0;
            line_q <= 1'b0;
        end else if (load) begin
            line_q <= frame[FRAME_W-1];
            sreg_q <= frame << 1;
            rem_q  <= len - LEN_W'(1);
        end else if (rem_q != '0) begin
            line_q <= sreg_q[FRAME_W-1];
            sreg_q <= sreg_q << 1;
            rem_q  <= rem_q - LEN_W'(1);
        end else begin
            line_q <= 1'b0;
        end
    end

    assign idle = (rem_q == '0);

    // R2
    stop_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == LEN_W'(1)) |=> !line_q);

endmodule

// File: rtl/lrq_tx.sv
// Module: lrq_tx (top)
// Serial link request transmitter. Accepts one request per valid/ready
// handshake and drives its framed bits on lreq, one per clock. Assumes the
// request fields are stable in the cycle the handshake completes.
module lrq_tx
    import lrq_pkg::*;
#(
    parameter int CODE_W  = CODE_W_DEF,
    parameter int SPEED_W = SPEED_W_DEF,
    parameter int PRIO_W  = PRIO_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [CODE_W-1:0]  req_code,
    input  logic [SPEED_W-1:0] req_speed,
    input  logic [PRIO_W-1:0]  req_prio,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               lreq
);
    localparam int BUS_MAX = 2 + CODE_W + SPEED_W + PRIO_W;
    localparam int REG_MAX = 2 + CODE_W + ADDR_W + DATA_W;
    localparam int FRAME_W = max_of(BUS_MAX, REG_MAX);
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic               accept;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;
    logic               shifter_idle;

    assign accept    = req_valid && req_ready;
    assign req_ready = shifter_idle;

    lrq_frame_build #(
        .CODE_W(CODE_W), .SPEED_W(SPEED_W), .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
    ) u_build (
        .kind  (req_kind_t'(req_kind)),
        .code  (req_code),
        .speed (req_speed),
        .prio  (req_prio),
        .addr  (req_addr),
        .wdata (req_wdata),
        .frame (frame),
        .len   (frame_len)
    );

    lrq_shift_out #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .frame  (frame),
        .len    (frame_len),
        .line_q (lreq),
        .idle   (shifter_idle)
    );

    // R2
    start_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> lreq);

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !lreq);

    // R8
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(req_ready) && !$past(accept)) |-> 1'b0);

endmodule

// File: tb/test_lrq_tx.sv
// Bench for lrq_tx: behavioural queue model of the serial stream, compared
// against lreq and req_ready on every falling clock edge.
module test_lrq_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = '0;
    logic [2:0] req_code = '0;
    logic [1:0] req_speed = '0;
    logic [3:0] req_prio = '0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       lreq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lrq_tx i_lrq_tx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_code(req_code), .req_speed(req_speed),
        .req_prio(req_prio), .req_addr(req_addr), .req_wdata(req_wdata),
        .lreq(lreq)
    );

    // Reference model state
    bit    bitq[$];
    string tagq[$];
    bit    exp_lreq  = 1'b0;
    bit    exp_ready = 1'b1;
    string cur_tag   = "R1";
    bit    last_acc  = 1'b0;
    bit    started   = 1'b0;
    int    exp_busy  = 0;
    string busy_tag  = "R8";
    int    busy_cnt  = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void push_field(input int value, input int width, input string tag);
        for (int i = width - 1; i >= 0; i--) begin
            bitq.push_back(bit'((value >> i) & 1));
            tagq.push_back(tag);
        end
    endfunction

    // Frame per R3..R6: start, code, kind-specific fields, stop; MSB first (R7).
    function automatic int push_frame();
        string t;
        int    n;
        n = bitq.size();
        case (req_kind)
            2'd0: t = "R3";
            2'd1: t = "R4";
            2'd2: t = "R5";
            default: t = "R6";
        endcase
        push_field(1, 1, "R2");
        push_field(int'(req_code), 3, {t, "/R7"});
        case (req_kind)
            2'd0: push_field(int'(req_speed), 2, {t, "/R7"});
            2'd1: begin
                push_field(int'(req_speed), 2, {t, "/R7"});
                push_field(int'(req_prio), 4, {t, "/R7"});
            end
            2'd2: push_field(int'(req_addr), 4, {t, "/R7"});
            default: begin
                push_field(int'(req_addr), 4, {t, "/R7"});
                push_field(int'(req_wdata), 8, {t, "/R7"});
            end
        endcase
        push_field(0, 1, "R2");
        busy_tag = t;
        return bitq.size() - n;
    endfunction

    // Model step on each rising edge: accept, then emit the next bit.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            bitq.delete();
            tagq.delete();
            exp_lreq  = 1'b0;
            exp_ready = 1'b1;
            last_acc  = 1'b0;
            cur_tag   = "R1";
        end else begin
            last_acc = req_valid && exp_ready;
            if (last_acc) exp_busy = push_frame() - 1;
            if (bitq.size() != 0) begin
                exp_lreq = bitq.pop_front();
                cur_tag  = tagq.pop_front();
            end else begin
                exp_lreq = 1'b0;
                cur_tag  = "R1";
            end
            exp_ready = (bitq.size() == 0);
        end
    end

    // Compare on every falling edge; also count ready-low cycles per frame (R8).
    always @(negedge clk) begin
        if (started && rst_n) begin
            check(cur_tag, int'(lreq), int'(exp_lreq));
            check("R8 ready", int'(req_ready), int'(exp_ready));
            if (!req_ready) busy_cnt++;
            else if (busy_cnt != 0) begin
                check({busy_tag, "/R8 length"}, busy_cnt, exp_busy);
                busy_cnt = 0;
            end
        end
    end

    // Issue one request; hold valid until accepted. With scramble set,
    // fields get random values while the block is busy (R9).
    task automatic send(input int kind, input int code, input int spd, input int pri,
                        input int addr, input int data, input bit scramble, input bit hold);
        @(negedge clk);
        req_kind  = 2'(kind);
        req_code  = 3'(code);
        req_speed = 2'(spd);
        req_prio  = 4'(pri);
        req_addr  = 4'(addr);
        req_wdata = 8'(data);
        req_valid = 1'b1;
        do begin
            @(posedge clk);
            @(negedge clk);
            if (!last_acc && scramble && !exp_ready) begin
                req_code  = 3'($urandom);
                req_speed = 2'($urandom);
                req_prio  = 4'($urandom);
                req_addr  = 4'($urandom);
                req_wdata = 8'($urandom);
                req_kind  = 2'($urandom);
            end
        end while (!last_acc);
        if (!hold) req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset lreq", int'(lreq), 0);
        check("R1 reset ready", int'(req_ready), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle lreq", int'(lreq), 0);
        // R3: cable request
        send(0, 5, 2, 0, 0, 0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        // R4: backplane request, two priorities
        send(1, 3, 1, 4'hA, 0, 0, 1'b0, 1'b0);
        repeat (14) @(negedge clk);
        send(1, 3, 1, 4'h5, 0, 0, 1'b0, 1'b0);
        repeat (14) @(negedge clk);
        // R5: register read
        send(2, 6, 0, 0, 4'h9, 0, 1'b0, 1'b0);
        repeat (12) @(negedge clk);
        // R6: register write
        send(3, 1, 0, 0, 4'h3, 8'hA5, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        // R8: back-to-back chain with valid held through stop bits
        send(0, 7, 3, 0, 0, 0, 1'b0, 1'b1);
        send(3, 2, 0, 0, 4'hC, 8'h3C, 1'b0, 1'b1);
        send(2, 4, 0, 0, 4'h1, 0, 1'b0, 1'b1);
        send(1, 0, 2, 4'h8, 0, 0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        // R9: fields scrambled while busy
        send(3, 5, 0, 0, 4'h6, 8'h81, 1'b0, 1'b1);
        send(1, 2, 3, 4'h1, 0, 0, 1'b1, 1'b1);
        send(2, 7, 0, 0, 4'hE, 0, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            send(k % 4, int'($urandom), int'($urandom), int'($urandom),
                 int'($urandom), int'($urandom), 1'b1, 1'b1);
        end
        req_valid = 1'b0;
        repeat (24) @(negedge clk);
        check("R1 final idle lreq", int'(lreq), 0);
        check("R1 final ready", int'(req_ready), 1);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule